// File: doc/BRIEF.md
# Multipurpose Lookup Table Pair

This block is a pair of 16-bit storage cells addressed by a 4-bit index, plus the multiplexing that joins them. One mode setting decides what the same storage bits do. In logic mode each cell is a truth table that is read combinationally. A fifth select input picks one of the two cells, so the pair computes any function of five inputs. In RAM mode each write lands in both cells at the primary address. The primary output reads the first cell at that same address and the secondary output reads the second cell through an independent read address, which gives a 16x1 memory with a second read-only port. In shift mode the first cell is a 16-stage serial shift register. Its last stage feeds the second cell, and the last stage of the second cell is driven to a cascade output so that further pairs can be chained.

The operating modes are named MODE_LOGIC, MODE_RAM, MODE_SHIFT and MODE_SPARE. The mode is taken straight from the mode input on every cycle, and changing it never alters the stored bits. The transitions inside a mode are these. In RAM mode, a cycle with the enable high is a write and a cycle with the enable low is a hold. In shift mode, a cycle with the enable high is a shift and a cycle with the enable low is a hold. In logic and spare modes, every cycle is a hold. Reset loads each cell from its own 16-bit parameter, in which bit k is the value at address k. Both parameters default to all zeros. A register behind the primary output gives a read with one cycle of latency.

Top module: `lutc_pair`

## Requirements
- R1: While reset is asserted, and from then until the first change, the low cell holds INIT_LO and the high cell holds INIT_HI. Bit k of each parameter is the value at address k.
- R2: In logic mode (mode 0), f_o equals HI[addr_i] when sel5_i is 1 and LO[addr_i] when sel5_i is 0, with no clock in the path.
- R3: In logic mode, we_i and din_i are ignored. No cell bit changes, which the bench reads back through f_o and f2_o.
- R4: In RAM mode (mode 1), a rising edge with we_i=1 stores din_i at addr_i in both cells. f_o reads LO[addr_i] combinationally, so it shows the old value before that edge and the new value after it.
- R5: f2_o equals HI[raddr_i] in every mode. In RAM mode this acts as a read-only second port at its own address.
- R6: In shift mode (mode 2), each rising edge with we_i=1 shifts din_i into LO bit 0 and moves LO bit k to bit k+1. f_o equals LO[addr_i], which is the input from addr_i+1 enabled shifts ago. With we_i=0 nothing moves.
- R7: In shift mode, HI shifts in the same way, taking LO bit 15 as its input. cascade_o equals HI bit 15 in every mode.
- R8: q_o is 0 in reset and otherwise equals the value f_o had just before the latest rising edge.
- R9: Mode code 3 behaves exactly like logic mode, including ignoring we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; reloads both cells from their parameters |
| mode_i | input | 2 | 0 logic, 1 RAM, 2 shift, 3 same as logic |
| addr_i | input | ADDR_W | Primary address: table index, write address or shift tap |
| raddr_i | input | ADDR_W | Secondary read address into the high cell |
| sel5_i | input | 1 | Fifth function input; selects the high cell in logic mode |
| din_i | input | 1 | Write data (RAM mode) or serial input (shift mode) |
| we_i | input | 1 | Write enable in RAM mode, shift enable in shift mode |
| f_o | output | 1 | Combinational primary output |
| f2_o | output | 1 | Combinational read of the high cell at raddr_i |
| q_o | output | 1 | f_o registered by one clock |
| cascade_o | output | 1 | Last stage of the high cell, for chaining pairs |

## Verification
Assertions inside each cell check on every clock that the stored vector stays put in logic, spare and RAM-hold cycles. They also check that an enabled RAM edge leaves the written bit equal to the data, and that an enabled shift edge yields exactly the old vector moved up by one with the serial input at the bottom. A top-level assertion checks that the output register tracks the primary output. Only the bench scenarios show the addressed views at the ports. These are the five-input selection across all 32 input combinations and the old-then-new read at an address being written. They also include the tap delay at varying taps, the second port reading independently, the 32-stage path to the cascade output, and contents surviving mode changes.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_SPARE = 2'd3
    } lut_mode_e;
endpackage

// File: rtl/lutc_store.sv
module lutc_store
    import lutc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [(1 << ADDR_W) - 1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lut_mode_e         mode_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic              wdata_i,
    input  logic              sin_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic              rdata_a_o,
    output logic              rdata_b_o,
    output logic              last_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] mem;

    // storage: behaviour chosen by the operating mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= INIT;
        end else begin
            unique case (mode_i)
                MODE_RAM: begin
                    if (we_i) mem[waddr_i] <= wdata_i;
                end
                MODE_SHIFT: begin
                    if (we_i) mem <= {mem[DEPTH-2:0], sin_i};
                end
                default: begin
                    // logic and spare modes: contents frozen
                end
            endcase
        end
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
    assign last_o    = mem[DEPTH-1];

    // R3 / R9: no edge changes the contents outside RAM and shift modes
    a_r3_logic_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LOGIC || mode_i == MODE_SPARE) |=> $stable(mem));

    // R4: an enabled RAM edge leaves the data at the written address
    a_r4_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RAM && we_i) |=> (mem[$past(waddr_i)] == $past(wdata_i)));

    // R4: a RAM cycle without enable keeps the contents
    a_r4_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RAM && !we_i) |=> $stable(mem));

    // R6: an enabled shift edge moves every stage up by one
    a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SHIFT && we_i) |=> (mem == {$past(mem[DEPTH-2:0]), $past(sin_i)}));

    // R6: a shift cycle without enable keeps the contents
    a_r6_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SHIFT && !we_i) |=> $stable(mem));
endmodule

// File: rtl/lutc_oreg.sv
module lutc_oreg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/lutc_pair.sv
module lutc_pair
    import lutc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [(1 << ADDR_W) - 1:0] INIT_LO = '0,
    parameter logic [(1 << ADDR_W) - 1:0] INIT_HI = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic              sel5_i,
    input  logic              din_i,
    input  logic              we_i,
    output logic              f_o,
    output logic              f2_o,
    output logic              q_o,
    output logic              cascade_o
);
    localparam int NCELL = 2;

    lut_mode_e        mode;
    logic [NCELL-1:0] rd_a;
    logic [NCELL-1:0] rd_b;
    logic [NCELL-1:0] last;
    logic [NCELL-1:0] sin;

    assign mode = lut_mode_e'(mode_i);

    // cell 0 takes the serial input; cell g takes the last stage of cell g-1
    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        if (g == 0) begin : g_head
            assign sin[g] = din_i;
        end else begin : g_link
            assign sin[g] = last[g-1];
        end
        lutc_store #(
            .ADDR_W(ADDR_W),
            .INIT  ((g == 0) ? INIT_LO : INIT_HI)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode),
            .we_i     (we_i),
            .waddr_i  (addr_i),
            .wdata_i  (din_i),
            .sin_i    (sin[g]),
            .raddr_a_i(addr_i),
            .raddr_b_i(raddr_i),
            .rdata_a_o(rd_a[g]),
            .rdata_b_o(rd_b[g]),
            .last_o   (last[g])
        );
    end

    // output selection per mode
    always_comb begin
        unique case (mode)
            MODE_RAM, MODE_SHIFT: f_o = rd_a[0];
            default:              f_o = sel5_i ? rd_a[NCELL-1] : rd_a[0];
        endcase
    end

    assign f2_o      = rd_b[NCELL-1];
    assign cascade_o = last[NCELL-1];

    lutc_oreg u_oreg (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (f_o),
        .q_o  (q_o)
    );

    // R8: the registered output lags the primary output by one edge
    a_r8_q_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_o == $past(f_o)));
endmodule

// File: tb/sim_lutc_pair.sv
`timescale 1ns/1ps
module sim_lutc_pair;
    localparam logic [15:0] LO0 = 16'hA2F5;
    localparam logic [15:0] HI0 = 16'h3C96;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [3:0] addr, raddr;
    logic       sel5, din, we;
    logic       f_o, f2_o, q_o, cascade_o;

    always #5 clk = ~clk;

    lutc_pair #(.ADDR_W(4), .INIT_LO(LO0), .INIT_HI(HI0)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_i(addr), .raddr_i(raddr),
        .sel5_i(sel5), .din_i(din), .we_i(we),
        .f_o(f_o), .f2_o(f2_o), .q_o(q_o), .cascade_o(cascade_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference: two 16-bit vectors and the registered output
    logic [15:0] mlo, mhi;
    logic        mq;

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    // one clock: drive, check combinational view, update model at the edge
    task automatic cyc(logic [1:0] m, logic [3:0] a, logic [3:0] ra,
                       logic s5, logic d, logic w, string tag);
        logic fexp;
        mode = m; addr = a; raddr = ra; sel5 = s5; din = d; we = w;
        #1;
        if (m == 2'd1 || m == 2'd2) fexp = mlo[a];
        else                        fexp = s5 ? mhi[a] : mlo[a];
        chk(tag, "f_o", f_o, fexp);
        chk((m == 2'd1) ? "R5" : tag, "f2_o", f2_o, mhi[ra]);
        chk("R7", "cascade_o", cascade_o, mhi[15]);
        chk("R8", "q_o", q_o, mq);
        @(posedge clk);
        mq = fexp;
        if (m == 2'd1 && w) begin
            mlo[a] = d;
            mhi[a] = d;
        end else if (m == 2'd2 && w) begin
            mhi = {mhi[14:0], mlo[15]};
            mlo = {mlo[14:0], d};
        end
        @(negedge clk);
    endtask

    task automatic sweep(logic [1:0] m, string tag);
        for (int k = 0; k < 32; k++)
            cyc(m, 4'(k), 4'(31 - k), k[4], 1'b0, 1'b0, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        rst_n = 1'b0; mode = 2'd0; addr = '0; raddr = '0;
        sel5 = 1'b0; din = 1'b0; we = 1'b0;
        mlo = LO0; mhi = HI0; mq = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "q_o in reset", q_o, 1'b0);
        #1;
        chk("R1", "f_o in reset", f_o, LO0[0]);
        chk("R1", "f2_o in reset", f2_o, HI0[0]);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: initial contents, every address of both cells
        sweep(2'd0, "R1");

        // R2: five-input function under random inputs
        for (int k = 0; k < 24; k++)
            cyc(2'd0, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R2");

        // R3: enable and data ignored in logic mode
        for (int k = 0; k < 16; k++)
            cyc(2'd0, 4'(k), 4'(k), 1'($urandom), ~mlo[k], 1'b1, "R3");
        sweep(2'd0, "R3");

        // R9: spare code acts as logic mode
        for (int k = 0; k < 16; k++)
            cyc(2'd3, 4'(k), 4'(k), 1'(k), ~mhi[k], 1'b1, "R9");
        sweep(2'd3, "R9");

        // R4: RAM writes, then read back
        for (int k = 0; k < 16; k++)
            cyc(2'd1, 4'(k), 4'(15 - k), 1'b0, 1'($urandom), 1'b1, "R4");
        for (int k = 0; k < 16; k++)
            cyc(2'd1, 4'(k), 4'($urandom), 1'b0, 1'($urandom), 1'b0, "R4");
        // R4: same address: old before the edge, new after it
        cyc(2'd1, 4'd5, 4'd5, 1'b0, ~mlo[5], 1'b1, "R4");
        cyc(2'd1, 4'd5, 4'd5, 1'b0, 1'b0, 1'b0, "R4");
        cyc(2'd1, 4'd9, 4'd2, 1'b0, ~mlo[9], 1'b1, "R4");
        cyc(2'd1, 4'd9, 4'd9, 1'b0, 1'b0, 1'b0, "R4");

        // R5: second port reads independently of the primary address
        for (int k = 0; k < 16; k++)
            cyc(2'd1, 4'($urandom), 4'(k), 1'b0, 1'b0, 1'b0, "R5");

        // R6: shift with varying taps, then hold
        for (int k = 0; k < 40; k++)
            cyc(2'd2, 4'($urandom), 4'($urandom), 1'b0, 1'($urandom), 1'b1, "R6");
        for (int k = 0; k < 8; k++)
            cyc(2'd2, 4'(k), 4'(k + 3), 1'b0, 1'($urandom), 1'b0, "R6");
        for (int k = 0; k < 16; k++)
            cyc(2'd2, 4'(k), 4'(15 - k), 1'b0, 1'(k % 3 == 0), 1'b1, "R6");

        // R7: long chain through both cells to the cascade output
        for (int k = 0; k < 40; k++)
            cyc(2'd2, 4'd15, 4'($urandom), 1'b0, 1'($urandom), 1'b1, "R7");

        // R2: contents kept across the return to logic mode
        sweep(2'd0, "R2");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end
endmodule